// File: doc/BRIEF.md
# Snoop Address Retry Driver

This block sits on the snooping side of a split-transaction address bus and owns this agent's share of a wired, multi-driver address-retry line. It watches the transfer-start and address-acknowledge strobes. For each transfer it starts, it collects a verdict from the snoop logic. If the snoop says the tenure must be retried, the block pulls the shared line low in the third bus cycle after the transfer start. It holds the line low until one bus cycle after the acknowledge. It then lets go of the line in the controlled way that a shared line needs. When no retry is needed, the block never drives the line at all.

Release is a timed three-step sequence. First the driver goes to high impedance for half a bus cycle. Then it actively drives the line high for exactly one bus cycle. Then it returns to high impedance. This restores the pulled-up level quickly without fighting other drivers. If the retried snoop hit modified data, the block also raises a bus request for the copy-back at the start of release. It holds that request until the arbiter grants the bus.

The block runs on the processor clock. A one-clock `bus_stb` strobe, issued once every `PCLK_PER_BUS` processor clocks, marks the processor clock edge that coincides with a bus clock edge. All bus inputs are sampled only on strobed edges. The half-cycle release gap and the drive-high pulse are timed in processor clocks. The tristate pad itself lives outside the block and is controlled by `retry_oe` and `retry_o`.

Top module: `snoop_retry_driver`

## Requirements
- R1: While reset is held, and on the first clock after it, `retry_oe`, `retry_o` and `bus_req` are all 0.
- R2: A transfer is accepted when `xfer_start` is 1 on a strobed edge while the block is idle. `retry_req` is sampled on the first and second strobed edges after that. If it was 1 on either, then from the second of those edges the block drives the line low (`retry_oe`=1, `retry_o`=0). The line is therefore low for the whole third bus cycle after the transfer start.
- R3: If `retry_req` is 0 on both of those strobed edges, `retry_oe` stays 0 for the whole transfer. A request seen only on the transfer-start edge, or only after the second edge, has no effect.
- R4: The line stays driven low until the strobed edge that follows the strobed edge on which `addr_ack` is first seen as 1. On that later edge `retry_oe` falls. `addr_ack` has no effect unless the line is being driven low.
- R5: After the low drive ends, `retry_oe` stays 0 for exactly `PCLK_PER_BUS/2` processor clocks.
- R6: The release gap is followed by exactly `PCLK_PER_BUS` processor clocks of `retry_oe`=1 with `retry_o`=1, after which `retry_oe` returns to 0. `retry_o` is 1 only during this pulse.
- R7: `xfer_start` is ignored from the moment a transfer is accepted until the block is idle again after the pulse (or after a no-retry verdict).
- R8: `copyback_req` is sampled together with `retry_req` on the same two strobed edges, and counts only on an edge where `retry_req` is also 1. If it counted, `bus_req` rises on the same edge where the low drive ends.
- R9: Once set, `bus_req` stays 1 until a strobed edge on which `bus_grant` is 1 and `bus_req` was already 1. It is 0 from that edge on. A grant on the edge that sets `bus_req` does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | One-clock strobe marking a bus clock edge |
| xfer_start | input | 1 | Transfer-start strobe from the bus, active high |
| addr_ack | input | 1 | Address-acknowledge strobe from the bus, active high |
| retry_req | input | 1 | Snoop verdict: the current tenure must be retried |
| copyback_req | input | 1 | Snoop verdict: the retried line needs a copy-back |
| bus_grant | input | 1 | Address bus grant from the arbiter |
| retry_oe | output | 1 | Output enable for the retry line pad |
| retry_o | output | 1 | Level driven on the retry line when enabled (0 = retry) |
| bus_req | output | 1 | Bus request for the copy-back |

## Verification
Some rules are checked on every cycle by the assertions. The state sequence may only enter its phases from the right predecessor: low drive only out of the snoop window, the acknowledged phase only on a strobed acknowledge, a new snoop only from idle. The pulse level always comes with the enable, and a pulse always follows a released cycle. The copy-back request holds until a grant. The release timer parks at zero. Exact timing has to come from the bench sweep, which compares every output on every processor clock against windows computed from the transfer-start, acknowledge and grant positions. That timing covers the third-cycle start of the low drive, the half-cycle gap, the one-bus-cycle pulse width and the release point of the request. The sweep also shows at the pins that verdicts at the wrong edges and stray strobes during a sequence change nothing.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Phases of one snooped address tenure as seen by the retry driver
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SNOOP,
        RS_HOLD,
        RS_ACKED,
        RS_GAP,
        RS_PULSE
    } rs_state_e;

    // What the block asks the retry-line pad to do
    typedef struct packed {
        logic en;
        logic level;
    } line_drive_t;

    // Processor clocks spent released before the drive-high pulse
    function automatic int gap_clocks(input int ratio);
        return (ratio / 2 < 1) ? 1 : ratio / 2;
    endfunction

    // Counter width able to hold ratio-1
    function automatic int cnt_width(input int ratio);
        return (ratio <= 2) ? 1 : $clog2(ratio);
    endfunction

endpackage

// File: rtl/sr_interval_timer.sv
module sr_interval_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/sr_copyback_req.sv
module sr_copyback_req (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic set,
    input  logic grant,
    output logic req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (set) begin
            req_q <= 1'b1;
        end else if (stb && grant && req_q) begin
            req_q <= 1'b0;
        end
    end

    assign req = req_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_q && !(stb && grant)) |=> req_q); // R9

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_q && stb && grant && !set) |=> !req_q); // R9

endmodule

// File: rtl/sr_retry_fsm.sv
module sr_retry_fsm
    import sr_pkg::*;
#(
    parameter int RATIO = 4,
    parameter int CW    = 2,
    parameter int GAP   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          xfer_start,
    input  logic          addr_ack,
    input  logic          retry_req,
    input  logic          copyback_req,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          cb_start,
    output line_drive_t   drv
);
    rs_state_e st_q, st_d;
    logic      second_q, second_d;   // first snoop edge already seen
    logic      hit_q, hit_d;         // retry verdict collected
    logic      cb_q, cb_d;           // copy-back verdict collected

    always_comb begin
        st_d     = st_q;
        second_d = second_q;
        hit_d    = hit_q;
        cb_d     = cb_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cb_start = 1'b0;
        case (st_q)
            RS_IDLE: begin
                if (stb && xfer_start) begin
                    st_d     = RS_SNOOP;
                    second_d = 1'b0;
                    hit_d    = 1'b0;
                    cb_d     = 1'b0;
                end
            end
            RS_SNOOP: begin
                if (stb) begin
                    cb_d = cb_q | (retry_req & copyback_req);
                    if (!second_q) begin
                        second_d = 1'b1;
                        hit_d    = hit_q | retry_req;
                    end else if (hit_q || retry_req) begin
                        st_d = RS_HOLD;
                    end else begin
                        st_d = RS_IDLE;
                    end
                end
            end
            RS_HOLD: begin
                if (stb && addr_ack) begin
                    st_d = RS_ACKED;
                end
            end
            RS_ACKED: begin
                if (stb) begin
                    st_d     = RS_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(GAP - 1);
                    cb_start = cb_q;
                end
            end
            RS_GAP: begin
                if (tmr_expired) begin
                    st_d     = RS_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RATIO - 1);
                end
            end
            RS_PULSE: begin
                if (tmr_expired) begin
                    st_d = RS_IDLE;
                end
            end
            default: st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= RS_IDLE;
            second_q <= 1'b0;
            hit_q    <= 1'b0;
            cb_q     <= 1'b0;
        end else begin
            st_q     <= st_d;
            second_q <= second_d;
            hit_q    <= hit_d;
            cb_q     <= cb_d;
        end
    end

    // Pad control decoded from the state register only
    always_comb begin
        drv.en    = (st_q == RS_HOLD) || (st_q == RS_ACKED) || (st_q == RS_PULSE);
        drv.level = (st_q == RS_PULSE);
    end

    AST_HOLD_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
        (st_q == RS_HOLD && $past(st_q) != RS_HOLD) |-> $past(st_q == RS_SNOOP && stb)); // R2

    AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == RS_ACKED && $past(st_q) != RS_ACKED)
            |-> $past(st_q == RS_HOLD && stb && addr_ack)); // R4

    AST_SNOOP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == RS_SNOOP && $past(st_q) != RS_SNOOP) |-> $past(st_q == RS_IDLE)); // R7

    AST_CB_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cb_start |-> (st_q == RS_ACKED && stb)); // R8

endmodule

// File: rtl/snoop_retry_driver.sv
module snoop_retry_driver #(
    parameter int PCLK_PER_BUS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_stb,
    input  logic xfer_start,
    input  logic addr_ack,
    input  logic retry_req,
    input  logic copyback_req,
    input  logic bus_grant,
    output logic retry_oe,
    output logic retry_o,
    output logic bus_req
);
    import sr_pkg::*;

    localparam int CW  = cnt_width(PCLK_PER_BUS);
    localparam int GAP = gap_clocks(PCLK_PER_BUS);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cb_start;
    line_drive_t   drv;

    sr_interval_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sr_retry_fsm #(.RATIO(PCLK_PER_BUS), .CW(CW), .GAP(GAP)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stb          (bus_stb),
        .xfer_start   (xfer_start),
        .addr_ack     (addr_ack),
        .retry_req    (retry_req),
        .copyback_req (copyback_req),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .cb_start     (cb_start),
        .drv          (drv)
    );

    sr_copyback_req u_cbreq (
        .clk   (clk),
        .rst   (rst),
        .stb   (bus_stb),
        .set   (cb_start),
        .grant (bus_grant),
        .req   (bus_req)
    );

    assign retry_oe = drv.en;
    assign retry_o  = drv.level;

    AST_PULSE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> retry_oe); // R6

    AST_GAP_BEFORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(retry_o) |-> $past(!retry_oe)); // R5

endmodule

// File: tb/snoop_retry_driver_test.sv
module snoop_retry_driver_test;
    localparam int CLK_PERIOD = 10;
    localparam int R = 4;
    localparam int H = R / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_stb = 1'b0, xfer_start = 1'b0, addr_ack = 1'b0;
    logic retry_req = 1'b0, copyback_req = 1'b0, bus_grant = 1'b0;
    logic retry_oe, retry_o, bus_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snoop_retry_driver #(.PCLK_PER_BUS(R)) uut (
        .clk (clk), .rst (rst), .bus_stb (bus_stb), .xfer_start (xfer_start),
        .addr_ack (addr_ack), .retry_req (retry_req), .copyback_req (copyback_req),
        .bus_grant (bus_grant), .retry_oe (retry_oe), .retry_o (retry_o), .bus_req (bus_req)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still summarizes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // One scenario: TS in bus cycle 0, verdict in bus cycle rq, AACK in a, grant in g
    task automatic run(input int rq, input bit cb, input int a, input int g, input bit noise);
        bit retry;
        int len, nmax;
        retry = (rq == 1 || rq == 2);
        nmax  = retry ? a + 2 : 2;
        len   = (a + 7) * R;
        for (int n = 0; n < len; n++) begin
            int b, i, lo_s, lo_e, gp_e, pu_s, pu_e, br_s, br_e;
            logic e_oe, e_o, e_br;
            string tg;
            b = n / R;
            i = n % R;
            bus_stb      = (i == R - 1);
            // R7: stray transfer starts during the sequence when noise is set
            xfer_start   = (b == 0) || (noise && b >= 1 && b <= nmax);
            // R4: stray acknowledge in the snoop window when noise is set
            addr_ack     = (b == a) || (noise && b == 2);
            retry_req    = (b == rq);
            copyback_req = cb && (b == rq);
            // R9: grant on the edge that sets the request must not clear it
            bus_grant    = (b == g) || (noise && b == a + 1);
            @(posedge clk);
            @(negedge clk);
            lo_s = 3 * R - 1;
            lo_e = (a + 2) * R - 2;
            gp_e = lo_e + H;
            pu_s = gp_e + 1;
            pu_e = pu_s + R - 1;
            br_s = (a + 2) * R - 1;
            br_e = (g + 1) * R - 2;
            e_oe = retry && ((n >= lo_s && n <= lo_e) || (n >= pu_s && n <= pu_e));
            e_o  = retry && (n >= pu_s && n <= pu_e);
            e_br = retry && cb && (n >= br_s && n <= br_e);
            if (!retry)                          tg = "R3";
            else if (n < lo_s)                   tg = "R2";
            else if (n >= lo_e - R && n <= lo_e + 1) tg = "R4";
            else if (n <= lo_e)                  tg = "R2";
            else if (n <= gp_e)                  tg = "R5";
            else if (n <= pu_e + 1)              tg = "R6";
            else                                 tg = noise ? "R7" : "R6";
            chk(tg, $sformatf("retry_oe rq=%0d a=%0d n=%0d nz=%0b", rq, a, n, noise), retry_oe, e_oe);
            chk(tg, $sformatf("retry_o rq=%0d a=%0d n=%0d", rq, a, n), retry_o, e_o);
            chk(cb ? "R9" : "R8", $sformatf("bus_req rq=%0d cb=%0b a=%0d g=%0d n=%0d", rq, cb, a, g, n),
                bus_req, e_br);
        end
        bus_stb = 1'b0; xfer_start = 1'b0; addr_ack = 1'b0;
        retry_req = 1'b0; copyback_req = 1'b0; bus_grant = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1", "retry_oe in reset", retry_oe, 1'b0);
        chk("R1", "retry_o in reset", retry_o, 1'b0);
        chk("R1", "bus_req in reset", bus_req, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "retry_oe after reset", retry_oe, 1'b0);
        chk("R1", "bus_req after reset", bus_req, 1'b0);
        // Sweep: verdict edge (0 and 3 are outside the window, R3), copy-back (R8),
        // acknowledge position, grant position, stray strobes
        for (int rq = 0; rq < 4; rq++)
            for (int cb = 0; cb < 2; cb++)
                for (int a = 3; a < 6; a++)
                    for (int gs = 0; gs < 2; gs++)
                        for (int nz = 0; nz < 2; nz++)
                            run(rq, cb[0], a, a + 2 + 2 * gs, nz[0]);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule